// File: doc/BRIEF.md
# Backplane Bus Slave Memory Emulator

This block sits on an asynchronous 16-bit-data parallel backplane bus as a passive slave and makes a local word memory appear as bus memory. Each time a master asserts its address strobe, the block decides whether the addressed page belongs to it. If it does, the block serves the read or write from an internal dual-port store and completes the strobe handshake. If it does not, the block stays silent and drives nothing, so physical memory boards elsewhere on the bus can answer.

Which pages belong to the block comes from a page table with one enable flag per page. The host loads the table as a single vector of flags. A second, independent host port reads and writes the store at any time and never produces bus traffic, so the host can inspect or preload memory while a bus master is running.

The address width `AW` and the page size `2**PAGE_SHIFT` bytes are parameters. A full-size build uses `AW = 18` and `PAGE_SHIFT = 12`, which gives 4 KB pages and 64 flags. The defaults (`AW = 12`, `PAGE_SHIFT = 6`) keep the same 64-page layout with a 2K-word store.

Top module: `bus_mem_slave`

## Requirements
- R1: After reset `bus_ssyn`, `bus_dout_en` and `bus_dout` are 0, and every page flag in `pt_flags` is 0.
- R2: Address, cycle type and write data are captured once, at the synchronized assertion of `bus_msyn`. Changes on those lines while the strobe stays asserted do not alter the cycle.
- R3: A cycle whose page flag is clear is ignored. `bus_ssyn` and `bus_dout_en` stay 0, and a write leaves the store unchanged. The page index is `bus_addr[AW-1:PAGE_SHIFT]`, and flag bit i governs page i.
- R4: `bus_ctl` = 00 (read) and 01 (read, pause variant) on an enabled page return the word at `bus_addr[AW-1:1]` on `bus_dout`. `bus_dout_en` is asserted together with `bus_ssyn`.
- R5: `bus_ctl` = 10 on an enabled page stores the full 16-bit `bus_din` word.
- R6: `bus_ctl` = 11 on an enabled page writes one byte only. `bus_addr[0]` = 0 selects `bus_din[7:0]` into bits 7:0, and `bus_addr[0]` = 1 selects `bus_din[15:8]` into bits 15:8. The other byte is kept.
- R7: `bus_ssyn` and the read data stay asserted while `bus_msyn` is held. Both are released at the third rising clock edge after `bus_msyn` is deasserted.
- R8: The host port reads and writes the store independently of the bus. Read data appears on `host_rdata` after the rising edge that samples `host_en` with `host_we` = 0.
- R9: If the host and the bus write the same word in the same clock, the bus data is stored, the host write is discarded, and `host_stall` is 1 during that clock. A host write to a different word in that clock is not stalled and is stored.
- R10: `pt_load` copies `pt_wdata` into the page table at the clock edge, and `pt_flags` reads the table back.
- R11: Every bus input passes through two synchronizer flops. Counting rising edges from the edge that first samples the asserted strobe, an enabled write raises `bus_ssyn` at the third edge and a read raises it at the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Bus byte address |
| bus_ctl | input | 2 | Cycle type: 00/01 read, 10 word write, 11 byte write |
| bus_msyn | input | 1 | Master strobe, active high |
| bus_din | input | 16 | Write data from the bus |
| bus_ssyn | output | 1 | Slave reply strobe, active high |
| bus_dout | output | 16 | Read data toward the bus |
| bus_dout_en | output | 1 | Enable for the read data drivers |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | AW-1 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |
| host_stall | output | 1 | Host write lost to a bus write of the same word |
| pt_load | input | 1 | Load the page table |
| pt_wdata | input | 2**(AW-PAGE_SHIFT) | New page flags |
| pt_flags | output | 2**(AW-PAGE_SHIFT) | Current page flags |

## Verification
A bus write and a host write can land in the same clock. When both target the same word they collide. The bench provokes this by counting two synchronizer edges after raising the strobe and then driving a host write to the bus word. It checks `host_stall` before the store edge and reads the word back afterwards, expecting the bus value. The same timing with a host write to a neighbouring word must show no stall and both values stored.

// File: rtl/bms_pkg.sv
package bms_pkg;

    localparam int DW = 16;
    localparam int LANES = DW / 8;

    typedef enum logic [1:0] {
        CYC_READ       = 2'b00,
        CYC_READ_PAUSE = 2'b01,
        CYC_WORD_WR    = 2'b10,
        CYC_BYTE_WR    = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ACK,
        ST_SKIP
    } slv_state_e;

    typedef struct packed {
        cyc_e          kind;
        logic          odd;
        logic [DW-1:0] data;
    } bus_req_t;

    function automatic logic is_write(cyc_e k);
        return k == CYC_WORD_WR || k == CYC_BYTE_WR;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(cyc_e k, logic odd);
        logic [LANES-1:0] m;
        case (k)
            CYC_WORD_WR: m = '1;
            CYC_BYTE_WR: m = odd ? 2'b10 : 2'b01;
            default:     m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bms_sync.sv
module bms_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bms_page_table.sv
module bms_page_table #(
    parameter int PW     = 6,
    parameter int NPAGES = 1 << PW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NPAGES-1:0] wdata,
    input  logic [PW-1:0]     page,
    output logic [NPAGES-1:0] flags,
    output logic              hit
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else if (load)
            flags <= wdata;
    end

    assign hit = flags[page];
endmodule

// File: rtl/bms_word_ram.sv
module bms_word_ram
    import bms_pkg::*;
#(
    parameter int WAW   = 11,
    parameter int DEPTH = 1 << WAW
) (
    input  logic             clk,
    input  logic             a_en,
    input  logic [LANES-1:0] a_be,
    input  logic [WAW-1:0]   a_addr,
    input  logic [DW-1:0]    a_wdata,
    output logic [DW-1:0]    a_rdata,
    input  logic             b_en,
    input  logic             b_we,
    input  logic [WAW-1:0]   b_addr,
    input  logic [DW-1:0]    b_wdata,
    output logic [DW-1:0]    b_rdata,
    output logic             b_stall
);
    logic a_wr;
    logic b_wr_ok;

    assign a_wr    = a_en && (a_be != '0);
    assign b_stall = b_en && b_we && a_wr && (a_addr == b_addr);
    assign b_wr_ok = b_en && b_we && !b_stall;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] qa;
        logic [7:0] qb;

        always_ff @(posedge clk) begin
            if (a_en && a_be[l])
                mem[a_addr] <= a_wdata[l*8 +: 8];
            if (b_wr_ok)
                mem[b_addr] <= b_wdata[l*8 +: 8];
            if (a_en)
                qa <= mem[a_addr];
            if (b_en)
                qb <= mem[b_addr];
        end

        assign a_rdata[l*8 +: 8] = qa;
        assign b_rdata[l*8 +: 8] = qb;
    end
endmodule

// File: rtl/bus_mem_slave.sv
module bus_mem_slave
    import bms_pkg::*;
#(
    parameter int AW         = 12,
    parameter int PAGE_SHIFT = 6,
    localparam int PW        = AW - PAGE_SHIFT,
    localparam int NPAGES    = 1 << PW,
    localparam int WAW       = AW - 1,
    localparam int SW        = AW + DW + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic [1:0]        bus_ctl,
    input  logic              bus_msyn,
    input  logic [DW-1:0]     bus_din,
    output logic              bus_ssyn,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_dout_en,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [WAW-1:0]    host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_stall,
    input  logic              pt_load,
    input  logic [NPAGES-1:0] pt_wdata,
    output logic [NPAGES-1:0] pt_flags
);
    // synchronized bus view
    logic [SW-1:0] s_vec;
    logic [AW-1:0] s_addr;
    logic [1:0]    s_ctl;
    logic [DW-1:0] s_din;
    logic          msyn_s;
    logic          msyn_d;
    logic          rise;
    bus_req_t      req;

    bms_sync #(.W(SW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_msyn, bus_ctl, bus_din, bus_addr}),
        .q   (s_vec)
    );

    assign {msyn_s, s_ctl, s_din, s_addr} = s_vec;
    assign rise = msyn_s && !msyn_d;
    assign req  = '{kind: cyc_e'(s_ctl), odd: s_addr[0], data: s_din};

    // page decision
    logic pt_hit;

    bms_page_table #(.PW(PW)) u_pt (
        .clk   (clk),
        .rst   (rst),
        .load  (pt_load),
        .wdata (pt_wdata),
        .page  (s_addr[AW-1:PAGE_SHIFT]),
        .flags (pt_flags),
        .hit   (pt_hit)
    );

    // slave state machine
    slv_state_e       state;
    logic             start;
    logic [LANES-1:0] ram_be;
    logic [DW-1:0]    ram_q;

    assign start  = (state == ST_IDLE) && rise && pt_hit;
    assign ram_be = start ? lane_mask(req.kind, req.odd) : '0;

    bms_word_ram #(.WAW(WAW)) u_ram (
        .clk     (clk),
        .a_en    (start),
        .a_be    (ram_be),
        .a_addr  (s_addr[AW-1:1]),
        .a_wdata (req.data),
        .a_rdata (ram_q),
        .b_en    (host_en),
        .b_we    (host_we),
        .b_addr  (host_addr),
        .b_wdata (host_wdata),
        .b_rdata (host_rdata),
        .b_stall (host_stall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            msyn_d      <= 1'b0;
            bus_ssyn    <= 1'b0;
            bus_dout_en <= 1'b0;
            bus_dout    <= '0;
        end else begin
            msyn_d <= msyn_s;
            case (state)
                ST_IDLE: begin
                    if (rise) begin
                        if (!pt_hit) begin
                            state <= ST_SKIP;
                        end else if (is_write(req.kind)) begin
                            bus_ssyn <= 1'b1;
                            state    <= ST_ACK;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    bus_dout    <= ram_q;
                    bus_dout_en <= 1'b1;
                    bus_ssyn    <= 1'b1;
                    state       <= ST_ACK;
                end
                ST_ACK: begin
                    if (!msyn_s) begin
                        bus_ssyn    <= 1'b0;
                        bus_dout_en <= 1'b0;
                        bus_dout    <= '0;
                        state       <= ST_IDLE;
                    end
                end
                ST_SKIP: begin
                    if (!msyn_s)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7
    ssyn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_ssyn && msyn_s) |=> bus_ssyn);

    // R7
    ssyn_release_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_ssyn && !msyn_s) |=> !bus_ssyn);

    // R4
    dout_en_with_ssyn_chk: assert property (@(posedge clk) disable iff (rst)
        bus_dout_en |-> bus_ssyn);

    // R11
    ssyn_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ssyn) |-> msyn_s);

    // R3
    skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> (!bus_ssyn && !bus_dout_en));

    // R9
    stall_then_ack_chk: assert property (@(posedge clk) disable iff (rst)
        host_stall |=> bus_ssyn);

endmodule

// File: tb/test_bus_mem_slave.sv
module test_bus_mem_slave;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 12;
    localparam int PAGE_SHIFT = 6;
    localparam int NPAGES     = 1 << (AW - PAGE_SHIFT);
    localparam int WORDS      = 1 << (AW - 1);
    localparam int WPP        = WORDS / NPAGES;
    localparam logic [63:0] PT_PAT = 64'hC3A5_0F69_96F0_5A3C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [AW-1:0]     bus_addr = '0;
    logic [1:0]        bus_ctl = '0;
    logic              bus_msyn = 1'b0;
    logic [15:0]       bus_din = '0;
    logic              bus_ssyn;
    logic [15:0]       bus_dout;
    logic              bus_dout_en;
    logic              host_en = 1'b0;
    logic              host_we = 1'b0;
    logic [AW-2:0]     host_addr = '0;
    logic [15:0]       host_wdata = '0;
    logic [15:0]       host_rdata;
    logic              host_stall;
    logic              pt_load = 1'b0;
    logic [NPAGES-1:0] pt_wdata = '0;
    logic [NPAGES-1:0] pt_flags;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] model [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_mem_slave #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) i_bus_mem_slave (
        .clk (clk), .rst (rst),
        .bus_addr (bus_addr), .bus_ctl (bus_ctl), .bus_msyn (bus_msyn), .bus_din (bus_din),
        .bus_ssyn (bus_ssyn), .bus_dout (bus_dout), .bus_dout_en (bus_dout_en),
        .host_en (host_en), .host_we (host_we), .host_addr (host_addr),
        .host_wdata (host_wdata), .host_rdata (host_rdata), .host_stall (host_stall),
        .pt_load (pt_load), .pt_wdata (pt_wdata), .pt_flags (pt_flags)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        summary();
    end

    function automatic logic [15:0] seed(int w);
        return 16'((w * 40503) ^ 16'h5A5A);
    endfunction

    task automatic host_write(input int w, input logic [15:0] d, output logic stall);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = (AW-1)'(w); host_wdata = d;
        #1 stall = host_stall;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input int w, output logic [15:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = (AW-1)'(w);
        @(negedge clk);
        host_en = 1'b0;
        d = host_rdata;
    endtask

    task automatic bus_begin(input logic [AW-1:0] a, input logic [1:0] c, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_ctl = c; bus_din = d; bus_msyn = 1'b1;
    endtask

    task automatic bus_wait(output logic ack, output int lat);
        ack = 1'b0;
        lat = 0;
        while (!ack && lat < 12) begin
            @(negedge clk);
            lat++;
            ack = bus_ssyn;
        end
    endtask

    task automatic bus_end(input logic ack);
        int rel;
        if (ack) begin
            logic held;
            held = 1'b1;
            repeat (3) begin
                @(negedge clk);
                held = held && bus_ssyn;
            end
            check(held, "R7 hold", {63'd0, held}, 64'd1);
            bus_msyn = 1'b0;
            rel = 0;
            while (bus_ssyn && rel < 8) begin
                @(negedge clk);
                rel++;
            end
            check(rel == 3, "R7 release edges", 64'(rel), 64'd3);
            check(!bus_dout_en, "R7 data release", {63'd0, bus_dout_en}, 64'd0);
        end else begin
            bus_msyn = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        logic ack, stall;
        int lat;
        logic [15:0] rd;
        logic [15:0] v;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!bus_ssyn && !bus_dout_en, "R1 strobes", {bus_ssyn, bus_dout_en}, 64'd0);
        check(bus_dout == 16'd0, "R1 dout", bus_dout, 64'd0);
        check(pt_flags == '0, "R1 flags", pt_flags, 64'd0);

        // R10: load table
        @(negedge clk);
        pt_load = 1'b1; pt_wdata = PT_PAT;
        @(negedge clk);
        pt_load = 1'b0;
        check(pt_flags == PT_PAT, "R10 readback", pt_flags, PT_PAT);

        // R8: host preload of the whole store
        for (int w = 0; w < WORDS; w++) begin
            model[w] = seed(w);
            host_write(w, model[w], stall);
        end
        for (int w = 0; w < WORDS; w += 37) begin
            host_read(w, rd);
            check(rd == model[w], "R8 host readback", rd, model[w]);
        end

        // page sweep
        for (int p = 0; p < NPAGES; p++) begin
            int w, w2;
            logic en;
            logic [15:0] bd;
            w  = p * WPP + (p % WPP);
            w2 = w ^ 1;
            en = PT_PAT[p];

            // R4 / R3 / R11 read
            bus_begin({(AW-1)'(w), 1'b0}, (p % 4 == 1) ? 2'b01 : 2'b00, 16'h0);
            bus_wait(ack, lat);
            if (en) begin
                check(ack && lat == 4, "R11 read latency", 64'(lat), 64'd4);
                check(bus_dout == model[w], "R4 read data", bus_dout, model[w]);
                check(bus_dout_en, "R4 dout_en", {63'd0, bus_dout_en}, 64'd1);
            end else begin
                check(!ack && !bus_dout_en, "R3 ignored read", {ack, bus_dout_en}, 64'd0);
            end
            bus_end(ack);

            // R5 / R3 word write
            v = ~model[w] + 16'(p);
            bus_begin({(AW-1)'(w), 1'b0}, 2'b10, v);
            bus_wait(ack, lat);
            if (en) begin
                check(ack && lat == 3, "R11 write latency", 64'(lat), 64'd3);
                model[w] = v;
            end else begin
                check(!ack, "R3 ignored write", {63'd0, ack}, 64'd0);
            end
            bus_end(ack);
            host_read(w, rd);
            check(rd == model[w], en ? "R5 word stored" : "R3 store untouched", rd, model[w]);

            // R6 byte write
            bd = {8'(p + 8'h11), 8'(p + 8'h77)};
            bus_begin({(AW-1)'(w2), p[0]}, 2'b11, bd);
            bus_wait(ack, lat);
            if (en) begin
                if (p[0]) model[w2][15:8] = bd[15:8];
                else      model[w2][7:0]  = bd[7:0];
            end
            check(ack == en, "R6 byte ack", {63'd0, ack}, {63'd0, en});
            bus_end(ack);
            host_read(w2, rd);
            check(rd == model[w2], "R6 byte lane", rd, model[w2]);
        end

        // R2: lines change while strobe held
        begin
            int w, wo;
            w  = 2 * WPP + 5;
            wo = 3 * WPP + 9;
            bus_begin({(AW-1)'(w), 1'b0}, 2'b10, 16'h1357);
            bus_wait(ack, lat);
            check(ack, "R2 ack", {63'd0, ack}, 64'd1);
            bus_addr = {(AW-1)'(wo), 1'b0};
            bus_din  = 16'hEEEE;
            bus_ctl  = 2'b11;
            model[w] = 16'h1357;
            bus_end(ack);
            host_read(w, rd);
            check(rd == 16'h1357, "R2 captured data", rd, 64'h1357);
            host_read(wo, rd);
            check(rd == model[wo], "R2 other word untouched", rd, model[wo]);
        end

        // R9: same-word collision
        begin
            int w;
            w = 2 * WPP + 7;
            bus_begin({(AW-1)'(w), 1'b0}, 2'b10, 16'hB0B0);
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            host_en = 1'b1; host_we = 1'b1; host_addr = (AW-1)'(w); host_wdata = 16'h4444;
            #1 check(host_stall, "R9 stall raised", {63'd0, host_stall}, 64'd1);
            @(negedge clk);
            host_en = 1'b0; host_we = 1'b0;
            model[w] = 16'hB0B0;
            bus_wait(ack, lat);
            bus_end(ack);
            host_read(w, rd);
            check(rd == 16'hB0B0, "R9 bus wins", rd, 64'hB0B0);
        end

        // R9: different words in the same clock
        begin
            int w, wh;
            w  = 2 * WPP + 11;
            wh = w + 1;
            bus_begin({(AW-1)'(w), 1'b0}, 2'b10, 16'hC1C1);
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            host_en = 1'b1; host_we = 1'b1; host_addr = (AW-1)'(wh); host_wdata = 16'h2D2D;
            #1 check(!host_stall, "R9 no stall", {63'd0, host_stall}, 64'd0);
            @(negedge clk);
            host_en = 1'b0; host_we = 1'b0;
            bus_wait(ack, lat);
            bus_end(ack);
            host_read(w, rd);
            check(rd == 16'hC1C1, "R9 bus word", rd, 64'hC1C1);
            host_read(wh, rd);
            check(rd == 16'h2D2D, "R9 host word", rd, 64'h2D2D);
        end

        // R10: clearing the table silences an enabled page
        @(negedge clk);
        pt_load = 1'b1; pt_wdata = '0;
        @(negedge clk);
        pt_load = 1'b0;
        check(pt_flags == '0, "R10 cleared", pt_flags, 64'd0);
        bus_begin({(AW-1)'(2 * WPP), 1'b0}, 2'b00, 16'h0);
        bus_wait(ack, lat);
        check(!ack, "R10 page now ignored", {63'd0, ack}, 64'd0);
        bus_end(ack);

        summary();
    end
endmodule